// File: doc/BRIEF.md
# Lookahead Adder-Subtractor with Overflow Flags

This block adds or subtracts two binary words of parameterised width in a single combinational path. A mode input selects the operation. In subtract mode the second operand is inverted bit by bit and a one is injected as the initial carry, so both operations use the same adder. The result is the two's-complement difference.

Each bit forms a propagate term and a generate term. The word is split into 4-bit lookahead groups. Each group computes all four of its carries directly from those terms and its own carry-in, in two-level form, with no ripple between the bits inside it. The groups are chained through their carry-outs.

Beside the result, the block reports three flags:
- the raw end carry;
- an unsigned overflow flag (a carry out when adding, a borrow when subtracting);
- a signed overflow flag, taken from the carry into and the carry out of the top bit.

Callers select whichever flag matches how they interpret the operands. The block has no clock and no state. There are no named states and no transitions.

Top module: `addsub_cla`

## Requirements
- R1: With `sub_mode`=0, `result` equals (`op_a`+`op_b`) mod 2^WIDTH and `carry_out` equals bit WIDTH of the full sum.
- R2: With `sub_mode`=1, `result` equals (`op_a`-`op_b`) mod 2^WIDTH, and `carry_out` is 1 exactly when `op_a` >= `op_b` as unsigned numbers.
- R3: `unsigned_ovf` is 1 when adding and the true sum exceeds 2^WIDTH-1, and when subtracting with `op_a` < `op_b` (borrow); otherwise 0.
- R4: `signed_ovf` is 1 exactly when the true two's-complement sum or difference lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: `signed_ovf` is 0 whenever the effective operands have opposite sign bits. This covers adding two operands of opposite sign and subtracting two operands of the same sign.
- R6: A carry leaves each 4-bit group exactly when the low bits up to and including that group overflow. It reaches the next group within the same evaluation (for example 0x0F+0x01 gives 0x10, and 0xFF+0x01 gives 0x00 with `carry_out`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | End carry out of the most significant bit |
| unsigned_ovf | output | 1 | Unsigned overflow (carry when adding, borrow when subtracting) |
| signed_ovf | output | 1 | Two's-complement overflow |

## Verification
The bench builds the block with WIDTH=8, which gives two lookahead groups and a single group-to-group carry link. At that width every pair of operands can be applied in both modes: 131072 vectors, each compared against a reference built from integer arithmetic. This covers every carry pattern inside a group and across the boundary, as well as every signed and unsigned overflow case. Directed tasks also hit the named corners: the 0x7F/0x80 sign limits, wrap-around at 0xFF, and borrow on subtraction.

// File: rtl/addsub_cla_pkg.sv
package addsub_cla_pkg;

    // Bits handled by one lookahead group.
    localparam int GRP_BITS = 4;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_mode_e;

endpackage

// File: rtl/addsub_pg_cell.sv
// Per-bit operand conditioning: conditional inversion of B, then propagate/generate.
module addsub_pg_cell #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             invert_b,
    output logic [WIDTH-1:0] prop,
    output logic [WIDTH-1:0] gen
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic b_eff;
        assign b_eff   = b[i] ^ invert_b;
        assign prop[i] = a[i] ^ b_eff;
        assign gen[i]  = a[i] & b_eff;
    end

endmodule

// File: rtl/addsub_cla_group.sv
// One 4-bit lookahead group: every carry expanded in two-level form from p/g and cin.
module addsub_cla_group (
    input  logic [3:0] prop,
    input  logic [3:0] gen,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       c_top_in,
    output logic       cout
);

    logic c1, c2, c3;

    assign c1 = gen[0]
              | (prop[0] & cin);

    assign c2 = gen[1]
              | (prop[1] & gen[0])
              | (prop[1] & prop[0] & cin);

    assign c3 = gen[2]
              | (prop[2] & gen[1])
              | (prop[2] & prop[1] & gen[0])
              | (prop[2] & prop[1] & prop[0] & cin);

    assign cout = gen[3]
                | (prop[3] & gen[2])
                | (prop[3] & prop[2] & gen[1])
                | (prop[3] & prop[2] & prop[1] & gen[0])
                | (prop[3] & prop[2] & prop[1] & prop[0] & cin);

    assign sum[0]   = prop[0] ^ cin;
    assign sum[1]   = prop[1] ^ c1;
    assign sum[2]   = prop[2] ^ c2;
    assign sum[3]   = prop[3] ^ c3;
    assign c_top_in = c3;

endmodule

// File: rtl/addsub_flags.sv
// Flag derivation from the carries around the most significant bit.
module addsub_flags
    import addsub_cla_pkg::*;
(
    input  op_mode_e mode,
    input  logic     c_msb_in,
    input  logic     c_msb_out,
    output logic     carry_out,
    output logic     unsigned_ovf,
    output logic     signed_ovf
);

    logic is_sub;

    assign is_sub       = (mode == OP_SUB);
    assign carry_out    = c_msb_out;
    // Adding: carry means overflow. Subtracting: missing carry means borrow.
    assign unsigned_ovf = c_msb_out ^ is_sub;
    assign signed_ovf   = c_msb_in ^ c_msb_out;

endmodule

// File: rtl/addsub_cla.sv
// Top: parameterised adder-subtractor from chained 4-bit lookahead groups.
module addsub_cla
    import addsub_cla_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             unsigned_ovf,
    output logic             signed_ovf
);

    localparam int NGRP = WIDTH / GRP_BITS;

    op_mode_e         mode;
    logic [WIDTH-1:0] prop;
    logic [WIDTH-1:0] gen;
    logic [NGRP:0]    grp_c;
    logic [NGRP-1:0]  grp_top_in;

    assign mode     = op_mode_e'(sub_mode);
    assign grp_c[0] = sub_mode;

    addsub_pg_cell #(.WIDTH(WIDTH)) u_pg (
        .a        (op_a),
        .b        (op_b),
        .invert_b (sub_mode),
        .prop     (prop),
        .gen      (gen)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        addsub_cla_group u_grp (
            .prop     (prop[k*GRP_BITS +: GRP_BITS]),
            .gen      (gen[k*GRP_BITS +: GRP_BITS]),
            .cin      (grp_c[k]),
            .sum      (result[k*GRP_BITS +: GRP_BITS]),
            .c_top_in (grp_top_in[k]),
            .cout     (grp_c[k+1])
        );
    end

    addsub_flags u_flags (
        .mode         (mode),
        .c_msb_in     (grp_top_in[NGRP-1]),
        .c_msb_out    (grp_c[NGRP]),
        .carry_out    (carry_out),
        .unsigned_ovf (unsigned_ovf),
        .signed_ovf   (signed_ovf)
    );

endmodule

// File: rtl/addsub_cla_chk.sv
// Property checker bound to addsub_cla; the block is combinational, so checks are immediate.
module addsub_cla_chk #(
    parameter int WIDTH = 8,
    parameter int NGRP  = WIDTH / 4
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             m,
    input logic [WIDTH-1:0] s,
    input logic             co,
    input logic             uo,
    input logic             so,
    input logic [NGRP:0]    gc
);

    logic [WIDTH-1:0] be;
    logic [WIDTH:0]   ref_add;
    logic [WIDTH:0]   ref_sub;
    logic             same_sign;
    logic [WIDTH+1:0] mk;
    logic [WIDTH+1:0] tot;

    assign be        = b ^ {WIDTH{m}};
    assign ref_add   = {1'b0, a} + {1'b0, b};
    assign ref_sub   = {1'b0, a} - {1'b0, b};
    assign same_sign = (a[WIDTH-1] == be[WIDTH-1]);

    always_comb begin
        if (!m) begin
            p_sum_r1: assert ({co, s} == ref_add)
                else $error("p_sum_r1 a=%0h b=%0h", a, b);
        end else begin
            p_diff_r2: assert ((s == ref_sub[WIDTH-1:0]) && (co == (a >= b)))
                else $error("p_diff_r2 a=%0h b=%0h", a, b);
        end
        p_uovf_r3: assert (uo == (m ? (a < b) : ref_add[WIDTH]))
            else $error("p_uovf_r3 a=%0h b=%0h m=%0b", a, b, m);
        p_sovf_r4: assert (so == (same_sign && (s[WIDTH-1] != a[WIDTH-1])))
            else $error("p_sovf_r4 a=%0h b=%0h m=%0b", a, b, m);
        if (!same_sign) begin
            p_no_sovf_r5: assert (!so)
                else $error("p_no_sovf_r5 a=%0h b=%0h m=%0b", a, b, m);
        end
        mk  = '0;
        tot = '0;
        for (int k = 0; k < NGRP; k++) begin
            mk  = ((WIDTH+2)'(1) << (4 * (k + 1))) - (WIDTH+2)'(1);
            tot = ({2'b00, a} & mk) + ({2'b00, be} & mk) + (WIDTH+2)'(m);
            p_grp_carry_r6: assert (gc[k+1] == tot[4*(k+1)])
                else $error("p_grp_carry_r6 group %0d", k);
        end
    end

endmodule

bind addsub_cla addsub_cla_chk #(.WIDTH(WIDTH)) u_chk (
    .a  (op_a),
    .b  (op_b),
    .m  (sub_mode),
    .s  (result),
    .co (carry_out),
    .uo (unsigned_ovf),
    .so (signed_ovf),
    .gc (grp_c)
);

// File: tb/tb_addsub_cla.sv
module tb_addsub_cla;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         sub_mode = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         unsigned_ovf;
    logic         signed_ovf;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    addsub_cla #(.WIDTH(W)) dut (
        .op_a         (op_a),
        .op_b         (op_b),
        .sub_mode     (sub_mode),
        .result       (result),
        .carry_out    (carry_out),
        .unsigned_ovf (unsigned_ovf),
        .signed_ovf   (signed_ovf)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: a=%0h b=%0h m=%0b actual=%0h expected=%0h",
                     req, what, op_a, op_b, sub_mode, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input bit m);
        op_a     = W'(a);
        op_b     = W'(b);
        sub_mode = m;
        #2;
    endtask

    // Reference values from integer arithmetic.
    task automatic check_all(input int a, input int b, input bit m);
        int ua, ub, full, sa, sb, st;
        bit exp_c, exp_u, exp_s;
        ua = a & 'hFF;
        ub = b & 'hFF;
        sa = (ua >= 128) ? ua - 256 : ua;
        sb = (ub >= 128) ? ub - 256 : ub;
        if (!m) begin
            full  = ua + ub;
            exp_c = (full > 255);
            exp_u = exp_c;
            st    = sa + sb;
        end else begin
            full  = ua - ub;
            exp_c = (ua >= ub);
            exp_u = (ua < ub);
            st    = sa - sb;
        end
        exp_s = (st > 127) || (st < -128);
        apply(a, b, m);
        chk(m ? "R2" : "R1", "result", int'(result), full & 'hFF);
        chk(m ? "R2" : "R1", "carry", int'(carry_out), int'(exp_c));
        chk("R3", "unsigned_ovf", int'(unsigned_ovf), int'(exp_u));
        chk("R4", "signed_ovf", int'(signed_ovf), int'(exp_s));
    endtask

    task automatic t_reset_state();
        apply(0, 0, 1'b0);
        chk("R1", "idle result", int'(result), 0);
        chk("R1", "idle carry", int'(carry_out), 0);
        chk("R3", "idle uovf", int'(unsigned_ovf), 0);
        chk("R4", "idle sovf", int'(signed_ovf), 0);
    endtask

    task automatic t_group_boundary();
        apply('h0F, 'h01, 1'b0);
        chk("R6", "0F+01", int'(result), 'h10);
        chk("R6", "0F+01 carry", int'(carry_out), 0);
        apply('hFF, 'h01, 1'b0);
        chk("R6", "FF+01", int'(result), 'h00);
        chk("R6", "FF+01 carry", int'(carry_out), 1);
        apply('h10, 'h01, 1'b1);
        chk("R6", "10-01", int'(result), 'h0F);
        chk("R6", "10-01 carry", int'(carry_out), 1);
    endtask

    task automatic t_signed_corners();
        apply('h7F, 'h01, 1'b0);
        chk("R4", "7F+01 sovf", int'(signed_ovf), 1);
        apply('h80, 'h01, 1'b1);
        chk("R4", "80-01 sovf", int'(signed_ovf), 1);
        apply('h7F, 'h80, 1'b0);
        chk("R5", "7F+80 sovf", int'(signed_ovf), 0);
        apply('h80, 'hFF, 1'b1);
        chk("R5", "80-FF sovf", int'(signed_ovf), 0);
    endtask

    task automatic t_unsigned_borrow();
        apply(3, 5, 1'b1);
        chk("R3", "3-5 uovf", int'(unsigned_ovf), 1);
        chk("R2", "3-5 result", int'(result), 'hFE);
        apply(5, 5, 1'b1);
        chk("R3", "5-5 uovf", int'(unsigned_ovf), 0);
        chk("R2", "5-5 carry", int'(carry_out), 1);
    endtask

    task automatic t_opposite_sign_sweep();
        for (int a = 0; a < 256; a += 7) begin
            for (int b = 0; b < 256; b += 5) begin
                apply(a, b, 1'b0);
                if (a[7] != b[7]) chk("R5", "add opp sign", int'(signed_ovf), 0);
                apply(a, b, 1'b1);
                if (a[7] == b[7]) chk("R5", "sub same sign", int'(signed_ovf), 0);
            end
        end
    endtask

    task automatic t_exhaustive();
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    check_all(a, b, m[0]);
                end
            end
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000 && !finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #5;
        t_reset_state();
        t_group_boundary();
        t_signed_corners();
        t_unsigned_borrow();
        t_opposite_sign_sweep();
        t_exhaustive();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule